// File: doc/BRIEF.md
# DRAM Refresh Timer and Burst Column Address Path

This block provides the refresh request and the DRAM address path of a small interleaved DRAM controller. A free-running timer divides the memory clock by two. After 128 of these divided ticks it raises a refresh request. The request stays raised until the master sequencer answers it with a refresh-access strobe.

A 7-bit column register follows the processor's low address field on every clock while the sequencer is idle. When an access begins, the register freezes. It then steps by one on each increment strobe to walk through a burst.

A 2:1 output multiplexer sends either the row field or the column register to the DRAM address pins. The processor write level passes through the same multiplexer. The DRAM write strobe can therefore only go active when the column side is selected. The column side is never selected during a refresh access. Write stays high through a CAS-before-RAS cycle, so large DRAMs do not drop into their test mode.

The sequencer and the RAS/CAS timing are outside this block. They reach it only as the strobes `idle_i`, `inc_i`, `ref_access_i` and `mux_sel_i`.

Top module: `dram_refresh_addr`

## Requirements
- R1: After reset is released, `ref_req_o` first rises at the 256th rising clock edge. The timer counts one tick on every even-numbered edge, and the request rises on the 128th tick.
- R2: Once raised, `ref_req_o` stays high on every edge where `ref_access_i` is low. An edge with `ref_access_i` high while the request is pending clears it.
- R3: Ticks are ignored while the request is pending, and the tick count restarts from zero when the request is raised. After a clear at edge E, the next request rises at edge E+256 if E is even and at edge E+255 if E is odd.
- R4: While `idle_i` is high, the column register takes `proc_addr_i` bits [9:3] on every edge.
- R5: While `idle_i` and `inc_i` are both low, the column register holds its value.
- R6: With `idle_i` low and `inc_i` high, the column register advances by exactly 1 per edge and wraps from 127 to 0.
- R7: When `idle_i` and `inc_i` are both high, the load takes priority over the increment.
- R8: When `mux_sel_i` is low, `dram_addr_o` equals `proc_addr_i` bits [16:10] (the row field) and `dram_we_no` is 1.
- R9: When `mux_sel_i` is high and `ref_access_i` is low, `dram_addr_o` equals the column register and `dram_we_no` equals the inverse of `proc_wr_i`.
- R10: While `ref_access_i` is high, the outputs behave as in R8 whatever the level of `mux_sel_i`. The refresh strobe takes priority.
- R11: During reset, `ref_req_o` is 0 and the column register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Sequencer idle; column register tracks the address |
| inc_i | input | 1 | Column increment strobe |
| ref_access_i | input | 1 | Refresh access strobe; clears the request |
| mux_sel_i | input | 1 | Selects the column side (1) or the row side (0) |
| proc_addr_i | input | 14 | Processor address bits [16:3] |
| proc_wr_i | input | 1 | Processor write level, active high |
| ref_req_o | output | 1 | Refresh request to the sequencer |
| dram_addr_o | output | 7 | Multiplexed DRAM address |
| dram_we_no | output | 1 | DRAM write enable, active low |

## Verification
The assertions check on every cycle:
- the hold-until-acknowledged behaviour and the clear of the refresh request;
- the load, hold and step of the column register, including load priority;
- the multiplexer routing, including the forced-inactive write strobe under refresh.

The exact refresh interval cannot be seen one cycle at a time, so only the bench scenarios show it. These are the first request 256 edges after reset, and the 255- or 256-edge interval after a clear at an odd or even edge. The bench sweeps all 128 column load values and runs an increment walk across the 127-to-0 wrap.

// File: rtl/dram_ra_pkg.sv
package dram_ra_pkg;
  typedef enum logic {
    SRC_ROW = 1'b0,
    SRC_COL = 1'b1
  } addr_src_e;
endpackage

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int TICKS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic req_o
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic             div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      div_q <= ~div_q;
      if (req_q) begin
        if (ack_i) req_q <= 1'b0;
      end else if (div_q) begin
        // restart count as soon as request is raised
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/col_counter.sv
module col_counter #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         inc_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i;
    else if (inc_i)  q_q <= q_q + 1'b1;
  end

  assign q_o = q_q;
endmodule

// File: rtl/addr_mux.sv
module addr_mux
  import dram_ra_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         sel_i,
  input  logic         force_row_i,
  input  logic [W-1:0] row_i,
  input  logic [W-1:0] col_i,
  input  logic         wr_i,
  output logic [W-1:0] addr_o,
  output logic         we_no
);
  addr_src_e src;

  always_comb begin
    src = (sel_i && !force_row_i) ? SRC_COL : SRC_ROW;
    // write rides the column side only; row side pins it high
    unique case (src)
      SRC_COL: begin addr_o = col_i; we_no = ~wr_i; end
      default: begin addr_o = row_i; we_no = 1'b1;  end
    endcase
  end
endmodule

// File: rtl/dram_refresh_addr.sv
module dram_refresh_addr #(
  parameter int COL_W     = 7,
  parameter int COL_LSB   = 3,
  parameter int REF_TICKS = 128,
  localparam int AW       = 2 * COL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        idle_i,
  input  logic                        inc_i,
  input  logic                        ref_access_i,
  input  logic                        mux_sel_i,
  input  logic [COL_LSB+AW-1:COL_LSB] proc_addr_i,
  input  logic                        proc_wr_i,
  output logic                        ref_req_o,
  output logic [COL_W-1:0]            dram_addr_o,
  output logic                        dram_we_no
);
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_bits;
  logic [COL_W-1:0] row_bits;

  assign col_bits = proc_addr_i[COL_LSB +: COL_W];
  assign row_bits = proc_addr_i[COL_LSB+COL_W +: COL_W];

  ref_timer #(.TICKS(REF_TICKS)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_access_i),
    .req_o  (ref_req_o)
  );

  col_counter #(.W(COL_W)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (idle_i),
    .inc_i  (inc_i),
    .d_i    (col_bits),
    .q_o    (col_q)
  );

  addr_mux #(.W(COL_W)) u_mux (
    .sel_i       (mux_sel_i),
    .force_row_i (ref_access_i),
    .row_i       (row_bits),
    .col_i       (col_q),
    .wr_i        (proc_wr_i),
    .addr_o      (dram_addr_o),
    .we_no       (dram_we_no)
  );
endmodule

// File: rtl/dram_refresh_addr_chk.sv
module dram_refresh_addr_chk #(
  parameter int COL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_i,
  input logic             inc_i,
  input logic             ref_access_i,
  input logic             mux_sel_i,
  input logic             proc_wr_i,
  input logic [COL_W-1:0] col_bits,
  input logic [COL_W-1:0] row_bits,
  input logic [COL_W-1:0] col_q,
  input logic [COL_W-1:0] dram_addr_o,
  input logic             dram_we_no,
  input logic             ref_req_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ref_req_o && !ref_access_i) |=> ref_req_o);

  // R2
  req_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ref_req_o && ref_access_i) |=> !ref_req_o);

  // R4
  col_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && idle_i) |=> (col_q == $past(col_bits)));

  // R5
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !idle_i && !inc_i) |=> $stable(col_q));

  // R6
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !idle_i && inc_i) |=> (col_q == COL_W'($past(col_q) + 1'b1)));

  // R8 R10
  row_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mux_sel_i || ref_access_i) |-> (dram_addr_o == row_bits && dram_we_no));

  // R9
  col_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_i && !ref_access_i) |-> (dram_addr_o == col_q && dram_we_no == !proc_wr_i));
endmodule

bind dram_refresh_addr dram_refresh_addr_chk #(.COL_W(COL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .idle_i       (idle_i),
  .inc_i        (inc_i),
  .ref_access_i (ref_access_i),
  .mux_sel_i    (mux_sel_i),
  .proc_wr_i    (proc_wr_i),
  .col_bits     (col_bits),
  .row_bits     (row_bits),
  .col_q        (col_q),
  .dram_addr_o  (dram_addr_o),
  .dram_we_no   (dram_we_no),
  .ref_req_o    (ref_req_o)
);

// File: tb/sim_dram_refresh_addr.sv
module sim_dram_refresh_addr;
  localparam int  CW = 7;
  localparam time TP = 20ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          idle_i = 1'b0, inc_i = 1'b0, ref_access_i = 1'b0;
  logic          mux_sel_i = 1'b0, proc_wr_i = 1'b0;
  logic [16:3]   proc_addr_i = '0;
  logic          ref_req_o;
  logic [CW-1:0] dram_addr_o;
  logic          dram_we_no;

  int checks = 0, errors = 0, cyc = 0;

  dram_refresh_addr u0 (.*);

  always #(TP/2) clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wait_req(output int at);
    while (!ref_req_o) step();
    at = cyc;
  endtask

  initial begin
    #(TP * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int rise, e;
    // R11 reset state
    mux_sel_i = 1'b1;
    #(TP * 3);
    chk("R11 req", ref_req_o, 0);
    chk("R11 col", dram_addr_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R4 R9 R8: load sweep over all column values
    idle_i = 1'b1;
    for (int v = 0; v < 128; v++) begin
      proc_addr_i = {7'((v * 37 + 5) & 127), 7'(v)};
      proc_wr_i   = v[0];
      mux_sel_i   = 1'b1;
      step();
      chk("R4 load", dram_addr_o, v);
      chk("R9 we", dram_we_no, v[0] ? 0 : 1);
      mux_sel_i = 1'b0; #1;
      chk("R8 row", dram_addr_o, (v * 37 + 5) & 127);
      chk("R8 we", dram_we_no, 1);
    end

    // R5 hold, R6 step with wrap
    proc_addr_i = {7'd3, 7'd120};
    step();
    idle_i = 1'b0; mux_sel_i = 1'b1; proc_addr_i = {7'd9, 7'd11};
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 hold", dram_addr_o, 120);
    end
    inc_i = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R6 step", dram_addr_o, (120 + k) % 128);
    end
    // R7 load wins over inc
    idle_i = 1'b1; proc_addr_i = {7'd9, 7'd55};
    step();
    chk("R7 prio", dram_addr_o, 55);
    idle_i = 1'b0; inc_i = 1'b0; mux_sel_i = 1'b0;
    chk("R1 early", ref_req_o, 0);

    // R1 first request
    wait_req(rise);
    chk("R1 first", rise, 256);

    // R2 pending holds
    for (int k = 0; k < 40; k++) begin
      step();
      chk("R2 hold", ref_req_o, 1);
    end

    // R3 two clears with opposite parity
    for (int n = 0; n < 2; n++) begin
      if ((cyc % 2) != n) step();
      ref_access_i = 1'b1; mux_sel_i = 1'b1; proc_wr_i = 1'b1; #1;
      chk("R10 addr", dram_addr_o, 9);
      chk("R10 we", dram_we_no, 1);
      step();
      e = cyc;
      ref_access_i = 1'b0; mux_sel_i = 1'b0;
      chk("R2 clear", ref_req_o, 0);
      wait_req(rise);
      chk("R3 interval", rise, e + ((e % 2 == 0) ? 256 : 255));
    end

    finish_run();
  end
endmodule